// File: doc/BRIEF.md
# Scratchpad-Buffered Memory Command Controller

This block is the memory-function layer of a single-wire serial EEPROM slave. It sits above the bit-timing and device-addressing layers, which hand it received bits, read-slot requests, a bus reset indication and an enable. In return it supplies the bit to place on the bus in the next read slot. It holds a 512-byte memory array, a 32-byte scratchpad, a 9-bit target address and a transfer status byte.

Writes never go to memory directly. The master fills the scratchpad and reads it back (or checks a CRC-16 returned by the block). It then issues a copy command that must repeat the address and status bytes exactly. Only on a match is the scratchpad range moved into memory, during a busy interval whose length is a parameter. Bits travel least significant bit first in every field.

Top module: `mfc_ctrl`

## Requirements
- R1: A command byte of 0Fh opens a scratchpad write, AAh a scratchpad read, 55h a copy and F0h a memory read. Any other command byte makes every read slot return 1 until the next bus reset.
- R2: A received 16-bit target address is stored with its upper 7 bits forced to zero. The first address byte is the low byte.
- R3: A scratchpad write stores each complete data byte at the scratchpad offset given by address bits 4:0, incrementing from there. The status byte has bit 7 = copy-accepted flag, bit 6 = 0, bit 5 = partial flag and bits 4:0 = offset of the last stored byte. A stored byte clears the partial flag, and receipt of the 0Fh command clears the copy-accepted flag.
- R4: Once offset 1Fh has been written, further data bytes in the same command are ignored and leave scratchpad and ending offset unchanged.
- R5: The partial flag is set in either of two cases. The first is a bus reset during scratchpad-write data while bits of an unfinished byte are pending (the scratchpad is not yet full); that byte is discarded. The second is the power-loss input. A bus reset in the same cycle as a received bit drops that bit.
- R6: During a scratchpad write that has filled offset 1Fh, the next 16 read slots return the bitwise inverse of a CRC-16 (x^16+x^15+x^2+1, reflected, cleared to 0). The CRC covers the command byte, both raw address bytes and every stored data byte, with its low byte first, followed by 1s. Read slots return 1 if offset 1Fh was not reached.
- R7: A scratchpad read returns the address low byte, the address high byte, the status byte, then scratchpad bytes from the start offset up to offset 1Fh, and 1s after that.
- R8: A copy whose three following bytes equal the address low byte, address high byte and status byte, in that order, sets the copy-accepted flag. It then writes scratchpad offsets start through ending offset (wrapping, 1 to 32 bytes) into the addressed page at the same offsets.
- R9: A copy whose authorization bytes differ in any byte changes no memory, leaves the flag clear and returns 1s until the next bus reset.
- R10: After an accepted copy, the block is busy for BUSY_CYCLES clocks. During that time received bits are ignored and read slots return 1. Afterwards, read slots return 0,1,0,1,... (bytes AAh) until a bus reset.
- R11: A memory read loads the target address from two bytes. It then streams memory from that address, returning 1s past address 1FFh, and leaves the status byte unchanged.
- R12: While the enable is low, received bits are ignored and the output is 1. After reset the output is 1 and address, status and scratchpad are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_reset | input | 1 | One-cycle pulse: a bus reset was detected |
| en | input | 1 | Memory layer selected by the addressing layer |
| rx_valid | input | 1 | A bit written by the master is present on rx_bit |
| rx_bit | input | 1 | Received bit value |
| tx_req | input | 1 | A read slot consumes the current tx_bit |
| power_loss | input | 1 | Supply dropped; scratchpad contents are suspect |
| tx_bit | output | 1 | Bit for the next read slot |

## Verification
A bus reset and the last bit of a data byte can arrive in the same cycle. The reset has to win, so the byte is not stored and the partial flag is raised because seven bits were already pending. The bench sends seven bits, then drives the eighth bit together with the reset pulse. It then reads the status and data back and expects the partial flag set, the old ending offset and an untouched scratchpad byte. The copy-busy interval overlapping with incoming bits and read slots is provoked the same way: the bench sends a full byte and takes read slots during the busy window, and expects all 1s followed by an alternating pattern that starts with 0.

// File: rtl/mfc_pkg.sv
package mfc_pkg;

    typedef enum logic [3:0] {
        ST_CMD,
        ST_WS_ADR,
        ST_WS_DAT,
        ST_RS,
        ST_CP_AUTH,
        ST_CP_BUSY,
        ST_CP_DONE,
        ST_RM_ADR,
        ST_RM_DAT,
        ST_HALT
    } mfc_state_e;

    localparam logic [7:0] OP_WR_SP  = 8'h0F;
    localparam logic [7:0] OP_RD_SP  = 8'hAA;
    localparam logic [7:0] OP_CP_SP  = 8'h55;
    localparam logic [7:0] OP_RD_MEM = 8'hF0;

    // reflected form of x^16 + x^15 + x^2 + 1
    localparam logic [15:0] CRC_POLY_REFL = 16'hA001;

endpackage

// File: rtl/mfc_crc16_step.sv
module mfc_crc16_step
    import mfc_pkg::*;
(
    input  logic [15:0] crc_i,
    input  logic        bit_i,
    output logic [15:0] crc_o
);
    logic fb;

    always_comb begin
        fb    = crc_i[0] ^ bit_i;
        crc_o = (crc_i >> 1) ^ (fb ? CRC_POLY_REFL : 16'h0000);
    end
endmodule

// File: rtl/mfc_rx_byte.sv
module mfc_rx_byte (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       shift,
    input  logic       bit_i,
    output logic [2:0] cnt_o,
    output logic [7:0] byte_o,
    output logic       done_o
);
    logic [2:0] cnt_d, cnt_q;
    logic [7:0] sh_d,  sh_q;

    always_comb begin
        cnt_d  = cnt_q;
        sh_d   = sh_q;
        byte_o = {bit_i, sh_q[7:1]};
        done_o = shift && (cnt_q == 3'd7);
        if (clr) begin
            cnt_d = '0;
        end else if (shift) begin
            cnt_d = cnt_q + 3'd1;
            sh_d  = byte_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sh_q  <= '0;
        end else begin
            cnt_q <= cnt_d;
            sh_q  <= sh_d;
        end
    end

    assign cnt_o = cnt_q;

    // a byte completes exactly on the eighth accepted bit
    AST_BYTE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !clr |=> cnt_q == 3'd0); // R3
endmodule

// File: rtl/mfc_store.sv
module mfc_store #(
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] cells_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells_q[i] <= '0;
        end else if (we) begin
            cells_q[waddr] <= wdata;
        end
    end

    assign rdata = cells_q[raddr];
endmodule

// File: rtl/mfc_ctrl.sv
module mfc_ctrl
    import mfc_pkg::*;
#(
    parameter int PAGES       = 16,
    parameter int BUSY_CYCLES = 64   // must be at least one page of bytes
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_reset,
    input  logic en,
    input  logic rx_valid,
    input  logic rx_bit,
    input  logic tx_req,
    input  logic power_loss,
    output logic tx_bit
);
    localparam int PAGE_BYTES = 32;               // fixed by status byte layout
    localparam int OFS_W      = $clog2(PAGE_BYTES);
    localparam int MEM_BYTES  = PAGES * PAGE_BYTES;
    localparam int AW         = $clog2(MEM_BYTES);
    localparam int PW         = AW + 1;
    localparam int BCW        = $clog2(BUSY_CYCLES + 1);

    typedef struct packed {
        mfc_state_e                  st;
        logic [AW-1:0]               ta;
        logic [OFS_W-1:0]            eo;
        logic                        pf;
        logic                        aa;
        logic [OFS_W-1:0]            wp;
        logic                        full;
        logic [15:0]                 crc;
        logic [1:0]                  hdr;
        logic [PW-1:0]               pos;
        logic [2:0]                  bi;
        logic [BCW-1:0]              busy;
        logic [OFS_W:0]              cpn;
        logic                        alt;
        logic [PAGE_BYTES-1:0][7:0]  sp;
    } regs_t;

    regs_t r_d, r_q;

    logic          rx_take, tx_take, adv, busy_act;
    logic [2:0]    rx_cnt;
    logic [7:0]    rx_byte;
    logic          byte_done;
    logic [15:0]   crc_nx;
    logic [7:0]    es, ta_lo, ta_hi, tx_byte, auth_exp, mem_rd;
    logic [PW-1:0] rs_idx;
    logic [OFS_W:0]   ncopy;
    logic [OFS_W-1:0] cp_ofs;
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [AW-1:0] new_ta;

    assign busy_act = (r_q.busy != '0);
    assign rx_take  = en && rx_valid && !bus_reset && !busy_act;
    assign tx_take  = en && tx_req && !bus_reset;

    mfc_rx_byte u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (bus_reset),
        .shift  (rx_take),
        .bit_i  (rx_bit),
        .cnt_o  (rx_cnt),
        .byte_o (rx_byte),
        .done_o (byte_done)
    );

    mfc_crc16_step u_crc (
        .crc_i (r_q.crc),
        .bit_i (rx_bit),
        .crc_o (crc_nx)
    );

    // copy engine: one byte per cycle at the start of the busy window
    assign ncopy     = {1'b0, OFS_W'(r_q.eo - r_q.ta[OFS_W-1:0])} + (OFS_W+1)'(1);
    assign cp_ofs    = OFS_W'(r_q.ta[OFS_W-1:0] + r_q.cpn[OFS_W-1:0]);
    assign mem_we    = busy_act && (r_q.cpn < ncopy);
    assign mem_waddr = {r_q.ta[AW-1:OFS_W], cp_ofs};

    mfc_store #(.DEPTH(MEM_BYTES)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (r_q.sp[cp_ofs]),
        .raddr (r_q.pos[AW-1:0]),
        .rdata (mem_rd)
    );

    // byte views of the registers
    always_comb begin
        es     = {r_q.aa, 1'b0, r_q.pf, r_q.eo};
        ta_lo  = r_q.ta[7:0];
        ta_hi  = 8'(r_q.ta >> 8);
        new_ta = AW'({rx_byte, r_q.ta[7:0]});
        rs_idx = PW'(r_q.ta[OFS_W-1:0]) + r_q.pos - PW'(3);
        case (r_q.hdr)
            2'd0:    auth_exp = ta_lo;
            2'd1:    auth_exp = ta_hi;
            default: auth_exp = es;
        endcase
    end

    // outgoing byte selection
    always_comb begin
        tx_byte = 8'hFF;
        adv     = 1'b0;
        case (r_q.st)
            ST_RS: begin
                adv = tx_take;
                if (r_q.pos == PW'(0))      tx_byte = ta_lo;
                else if (r_q.pos == PW'(1)) tx_byte = ta_hi;
                else if (r_q.pos == PW'(2)) tx_byte = es;
                else if (rs_idx < PW'(PAGE_BYTES)) tx_byte = r_q.sp[rs_idx[OFS_W-1:0]];
            end
            ST_RM_DAT: begin
                adv = tx_take;
                if (r_q.pos < PW'(MEM_BYTES)) tx_byte = mem_rd;
            end
            ST_WS_DAT: begin
                adv = tx_take && r_q.full;
                if (r_q.full && r_q.pos < PW'(2))
                    tx_byte = ~(r_q.pos[0] ? r_q.crc[15:8] : r_q.crc[7:0]);
            end
            default: tx_byte = 8'hFF;
        endcase
    end

    assign tx_bit = !en ? 1'b1 :
                    (r_q.st == ST_CP_DONE) ? r_q.alt : tx_byte[r_q.bi];

    // next-state computation
    always_comb begin
        r_d = r_q;

        if (busy_act) begin
            r_d.busy = r_q.busy - BCW'(1);
            if (mem_we) r_d.cpn = r_q.cpn + (OFS_W+1)'(1);
            if (r_q.busy == BCW'(1) && r_q.st == ST_CP_BUSY) r_d.st = ST_CP_DONE;
        end

        if (adv) begin
            r_d.bi = r_q.bi + 3'd1;
            if (r_q.bi == 3'd7 && r_q.pos != '1) r_d.pos = r_q.pos + PW'(1);
        end
        if (tx_take && r_q.st == ST_CP_DONE) r_d.alt = ~r_q.alt;

        if (rx_take) begin
            if (r_q.st == ST_CMD || r_q.st == ST_WS_ADR ||
                (r_q.st == ST_WS_DAT && !r_q.full))
                r_d.crc = crc_nx;
            if (byte_done) begin
                case (r_q.st)
                    ST_CMD: begin
                        r_d.hdr = '0;
                        r_d.pos = '0;
                        r_d.bi  = '0;
                        case (rx_byte)
                            OP_WR_SP: begin
                                r_d.aa = 1'b0;
                                r_d.st = ST_WS_ADR;
                            end
                            OP_RD_SP:  r_d.st = ST_RS;
                            OP_CP_SP:  r_d.st = ST_CP_AUTH;
                            OP_RD_MEM: r_d.st = ST_RM_ADR;
                            default:   r_d.st = ST_HALT;
                        endcase
                    end
                    ST_WS_ADR, ST_RM_ADR: begin
                        if (r_q.hdr == 2'd0) begin
                            r_d.ta[7:0] = rx_byte;
                            r_d.hdr     = 2'd1;
                        end else begin
                            r_d.ta  = new_ta;
                            r_d.bi  = '0;
                            if (r_q.st == ST_WS_ADR) begin
                                r_d.wp   = r_q.ta[OFS_W-1:0];
                                r_d.full = 1'b0;
                                r_d.pos  = '0;
                                r_d.st   = ST_WS_DAT;
                            end else begin
                                r_d.pos = PW'(new_ta);
                                r_d.st  = ST_RM_DAT;
                            end
                        end
                    end
                    ST_WS_DAT: begin
                        if (!r_q.full) begin
                            r_d.sp[r_q.wp] = rx_byte;
                            r_d.eo         = r_q.wp;
                            r_d.pf         = 1'b0;
                            if (r_q.wp == '1) r_d.full = 1'b1;
                            else              r_d.wp   = r_q.wp + OFS_W'(1);
                        end
                    end
                    ST_CP_AUTH: begin
                        if (rx_byte != auth_exp) begin
                            r_d.st = ST_HALT;
                        end else if (r_q.hdr == 2'd2) begin
                            r_d.aa   = 1'b1;
                            r_d.busy = BCW'(BUSY_CYCLES);
                            r_d.cpn  = '0;
                            r_d.alt  = 1'b0;
                            r_d.st   = ST_CP_BUSY;
                        end else begin
                            r_d.hdr = r_q.hdr + 2'd1;
                        end
                    end
                    default: ;
                endcase
            end
        end

        if (bus_reset) begin
            if (r_q.st == ST_WS_DAT && !r_q.full && rx_cnt != 3'd0) r_d.pf = 1'b1;
            r_d.st  = ST_CMD;
            r_d.crc = '0;
            r_d.hdr = '0;
            r_d.pos = '0;
            r_d.bi  = '0;
        end

        if (power_loss) r_d.pf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_CMD;
        end else begin
            r_q <= r_d;
        end
    end

    AST_HALT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st == ST_HALT |-> tx_bit); // R1
    AST_AA_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st == ST_CMD && byte_done && rx_byte == OP_WR_SP && !bus_reset |=> !r_q.aa); // R3
    AST_FULL_FREEZES_EO: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st == ST_WS_DAT && r_q.full |=> $stable(r_q.eo)); // R4
    AST_PARTIAL_SETS_PF: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st == ST_WS_DAT && !r_q.full && rx_cnt != 3'd0 && bus_reset |=> r_q.pf); // R5
    AST_CRC_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        en && r_q.st == ST_WS_DAT && !r_q.full |-> tx_bit); // R6
    AST_COPY_SETS_AA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_act) |-> r_q.aa); // R8
    AST_BUSY_IGNORES_RX: assert property (@(posedge clk) disable iff (!rst_n)
        busy_act && rx_valid |=> $stable(r_q.ta)); // R10
    AST_DISABLED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> tx_bit); // R12
endmodule

// File: tb/mfc_ctrl_tb.sv
module mfc_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BUSY       = 64;

    logic clk, rst_n, bus_reset, en, rx_valid, rx_bit, tx_req, power_loss, tx_bit;
    int checks = 0;
    int errors = 0;

    // behavioural reference state
    logic [7:0]  m_mem [512];
    logic [7:0]  m_sp  [32];
    int          m_ta, m_eo;
    bit          m_pf, m_aa, m_full;
    logic [15:0] m_crc;
    logic [7:0]  q [$];

    mfc_ctrl #(.PAGES(16), .BUSY_CYCLES(BUSY)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .en(en),
        .rx_valid(rx_valid), .rx_bit(rx_bit), .tx_req(tx_req),
        .power_loss(power_loss), .tx_bit(tx_bit)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] crc_byte(logic [15:0] c, logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            logic fb;
            fb = c[0] ^ b[i];
            c  = c >> 1;
            if (fb) c = c ^ 16'hA001;
        end
        return c;
    endfunction

    function automatic logic [7:0] m_es();
        return {m_aa, 1'b0, m_pf, 5'(m_eo)};
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(bit b);
        @(negedge clk); rx_valid = 1'b1; rx_bit = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic send_byte(logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    task automatic get_byte(output logic [7:0] v);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); tx_req = 1'b1; v[i] = tx_bit;
            @(negedge clk); tx_req = 1'b0;
        end
    endtask

    task automatic breset();
        @(negedge clk); bus_reset = 1'b1;
        @(negedge clk); bus_reset = 1'b0;
    endtask

    task automatic expect_byte(string req, logic [7:0] exp);
        logic [7:0] got;
        get_byte(got);
        chk(req, got, exp);
    endtask

    // scratchpad write of the bytes held in q
    task automatic do_ws(int addr);
        int w;
        breset();
        send_byte(8'h0F); send_byte(8'(addr)); send_byte(8'(addr >> 8));
        m_aa = 0; m_ta = addr & 'h1FF; w = m_ta & 31; m_full = 0;
        m_crc = crc_byte(16'h0, 8'h0F);
        m_crc = crc_byte(m_crc, 8'(addr));
        m_crc = crc_byte(m_crc, 8'(addr >> 8));
        foreach (q[k]) begin
            send_byte(q[k]);
            if (!m_full) begin
                m_sp[w] = q[k]; m_eo = w; m_pf = 0;
                m_crc = crc_byte(m_crc, q[k]);
                if (w == 31) m_full = 1; else w++;
            end
        end
    endtask

    task automatic check_rs(int n, string req);
        breset();
        send_byte(8'hAA);
        expect_byte({req, " ta low"}, 8'(m_ta));
        expect_byte({req, " ta high"}, 8'(m_ta >> 8));
        expect_byte({req, " status"}, m_es());
        for (int k = 0; k < n; k++) begin
            int idx;
            idx = (m_ta & 31) + k;
            expect_byte({req, " scratch data"}, idx < 32 ? m_sp[idx] : 8'hFF);
        end
    endtask

    task automatic do_copy(logic [7:0] a, logic [7:0] b, logic [7:0] c);
        breset();
        send_byte(8'h55); send_byte(a); send_byte(b); send_byte(c);
        if (a == 8'(m_ta) && b == 8'(m_ta >> 8) && c == m_es()) begin
            int ofs, n;
            m_aa = 1;
            ofs = m_ta & 31;
            n = ((m_eo - ofs) & 31) + 1;
            for (int k = 0; k < n; k++) begin
                int o;
                o = (ofs + k) & 31;
                m_mem[(m_ta & 'h1E0) | o] = m_sp[o];
            end
        end
    endtask

    task automatic check_rm(int addr, int n, string req);
        breset();
        send_byte(8'hF0); send_byte(8'(addr)); send_byte(8'(addr >> 8));
        m_ta = addr & 'h1FF;
        for (int k = 0; k < n; k++) begin
            int a;
            a = m_ta + k;
            expect_byte(req, a < 512 ? m_mem[a] : 8'hFF);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements): got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] got;
        rst_n = 0; bus_reset = 0; en = 1; rx_valid = 0; rx_bit = 0; tx_req = 0; power_loss = 0;
        for (int i = 0; i < 512; i++) m_mem[i] = 8'h00;
        for (int i = 0; i < 32; i++) m_sp[i] = 8'h00;
        m_ta = 0; m_eo = 0; m_pf = 0; m_aa = 0; m_full = 0; m_crc = 0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R12: idle output and cleared registers after reset
        @(negedge clk); chk("R12 reset output", tx_bit, 1);
        check_rs(2, "R12 reset contents");

        // R3 / R7: two bytes at 0026h
        q.delete(); q.push_back(8'hA5); q.push_back(8'h3C);
        do_ws('h0026);
        check_rs(2, "R3 R7 write readback");

        // R8 / R10: authorized copy, traffic during busy, then pattern
        do_copy(8'h26, 8'h00, 8'h07);
        send_byte(8'hFF);
        expect_byte("R10 busy reads ones", 8'hFF);
        repeat (BUSY + 8) @(negedge clk);
        expect_byte("R10 alternating first", 8'hAA);
        expect_byte("R10 alternating second", 8'hAA);
        check_rs(0, "R8 accepted flag");

        // R11: memory read shows copied data, status unchanged
        check_rm('h0020, 8, "R8 R11 memory contents");
        check_rs(0, "R11 status kept after memory read");

        // R2 / R4 / R6: address masking, fill to 1Fh, extra byte, CRC
        q.delete();
        q.push_back(8'h11); q.push_back(8'h22); q.push_back(8'h33);
        q.push_back(8'h44); q.push_back(8'h55);
        do_ws('hFE5C);
        chk("R4 scratchpad full", m_full, 1);
        expect_byte("R6 crc low inverted", ~m_crc[7:0]);
        expect_byte("R6 crc high inverted", ~m_crc[15:8]);
        expect_byte("R6 ones after crc", 8'hFF);
        check_rs(6, "R2 R4 R7 masked address and end of scratchpad");

        // R9: wrong status byte in authorization
        do_copy(8'h5C, 8'h00, 8'h1E);
        expect_byte("R9 halted after mismatch", 8'hFF);
        check_rm('h005C, 4, "R9 memory untouched");
        check_rs(0, "R9 flag clear");

        // R8: correct authorization for the partial page
        do_copy(8'h5C, 8'h00, 8'h1F);
        repeat (BUSY + 8) @(negedge clk);
        check_rm('h005A, 6, "R8 copy of offsets 1C to 1F");

        // R11: run past the end of memory
        check_rm('h01FE, 4, "R11 end of memory");

        // R5: reset lands together with the eighth bit of a byte
        q.delete(); q.push_back(8'h77);
        do_ws('h0100);
        for (int i = 0; i < 7; i++) send_bit(1'b0);
        @(negedge clk); rx_valid = 1; rx_bit = 1; bus_reset = 1;
        @(negedge clk); rx_valid = 0; bus_reset = 0;
        m_pf = 1;
        check_rs(2, "R5 partial byte with same-cycle reset");

        // R6: no CRC when offset 1Fh not reached; R3 clears the flag
        q.delete(); q.push_back(8'h01);
        do_ws('h0000);
        expect_byte("R6 no crc when not full", 8'hFF);
        check_rs(1, "R3 valid write clears partial flag");

        // R5: power loss
        @(negedge clk); power_loss = 1;
        @(negedge clk); power_loss = 0;
        m_pf = 1;
        check_rs(0, "R5 power loss");

        // R1: unknown command
        breset();
        send_byte(8'h33);
        expect_byte("R1 unknown command", 8'hFF);
        check_rs(0, "R1 recovers after reset");

        // R12: disabled layer ignores bits
        breset();
        en = 0;
        @(negedge clk); chk("R12 disabled output", tx_bit, 1);
        send_byte(8'hF0);
        en = 1;
        send_byte(8'hAA);
        expect_byte("R12 ta low after ignored bits", 8'(m_ta));
        expect_byte("R12 ta high after ignored bits", 8'(m_ta >> 8));
        expect_byte("R12 status after ignored bits", m_es());

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule